// File: doc/BRIEF.md
# Boot Region Command Decoder

This block watches host writes to the two boot-buffer windows of a flash controller's register space and interprets the written values as boot commands. It runs a two-write load protocol: an arming value is followed by a confirming value. The confirmation produces a single-page load request aimed at the current block and page address, and the page address then moves on by one page. A second command fills three identification words. A third command produces a warm-reset pulse.

The block owns the 8-bit page address register, which the host can also write directly. The block address comes from outside. The load request waits in a one-entry holding register until the page-transfer engine reports ready. It then appears as a one-cycle pulse that carries the sector address. The transfer engine itself is not part of this block.

Top module: `boot_cmd_decoder`

## Requirements
- R1: A write with `wr_en` high is decoded as a boot command only when `wr_addr` is in 0x0000..0x01FF or 0x8000..0x800F. Writes to any other address change neither `page_addr`, `id_words`, `load_armed` nor the request outputs, and raise no `warm_rst`.
- R2: A decoded write of 0x00E0 while not armed sets `load_armed` from the next cycle. It has no other effect.
- R3: While armed, the next decoded write clears `load_armed` whatever its value. Only the value 0x0000 confirms a load. Any other value, 0x00F0 and 0x0090 included, is consumed and has no further effect.
- R4: A confirmed load targets sector `{blk_field, page_addr[7:0]}`. Here `page_addr[1:0]` is the sector in the page and `page_addr[7:2]` is the page. `blk_field` is `blk_addr[BLK_W-1:0]`, ORed with parameter `DENS_MASK` when `blk_addr[15]` is 1.
- R5: `load_req` is high only while `eng_rdy` is high. A confirmed request waits while `eng_rdy` is low. It is issued as exactly one cycle of `load_req` with `load_sec` valid. A new confirmation while a request still waits replaces it.
- R6: From the cycle after a confirmed load, `page_addr` equals the old value plus 4, modulo 256. A host page write (`pg_wr`) in the same cycle takes precedence, and the request still uses the old page.
- R7: A decoded write of 0x00F0 while not armed makes `warm_rst` high for exactly the next cycle and leaves `load_armed` low.
- R8: A decoded write of 0x0090 while not armed loads `id_words` from the next cycle. Bits [15:0] become `{8'h00, mfr_id}`, bits [31:16] become `{8'h00, dev_id}`, and bits [47:32] become `{8'h00, prot_status[7:0]}`.
- R9: Any other decoded value written while not armed is ignored.
- R10: After reset, `load_armed`, `load_req`, `warm_rst`, `page_addr` and `id_words` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host write word offset |
| wr_data | input | 16 | Host write value |
| pg_wr | input | 1 | Direct write of the page address register |
| pg_wdata | input | 8 | Value for the page address register |
| blk_addr | input | 16 | Current block address register |
| mfr_id | input | 8 | Manufacturer identification byte |
| dev_id | input | 8 | Device identification byte |
| prot_status | input | 16 | Write-protection status |
| eng_rdy | input | 1 | Transfer engine can accept a request |
| load_req | output | 1 | One-cycle page load request |
| load_sec | output | BLK_W+8 | Sector address of the request |
| page_addr | output | 8 | Page address register |
| warm_rst | output | 1 | Warm-reset pulse |
| load_armed | output | 1 | Load command armed, awaiting confirmation |
| id_words | output | 48 | Three identification words |

## Verification
The hardest case to reach is a command value written as the second half of the load protocol. A reset or identify code written while armed looks exactly like a real command at the port, yet it must be swallowed. The stimulus arms with 0x00E0, then writes 0x00F0 or 0x0090, and then writes 0x0000 to show that the arm is gone. A second hard case is a waiting request that a fresh confirmation replaces while the engine is held not ready. The bench holds `eng_rdy` low across two confirmations before it releases the engine. It then sweeps all 256 page values through the confirm path and checks the sector address and the wrapped page advance arithmetically.

// File: rtl/boot_cmd_decoder.sv
module boot_cmd_decoder #(
  parameter int BLK_W = 12,
  parameter logic [BLK_W-1:0] DENS_MASK = 12'h800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [15:0]      wr_data,
  input  logic             pg_wr,
  input  logic [7:0]       pg_wdata,
  input  logic [15:0]      blk_addr,
  input  logic [7:0]       mfr_id,
  input  logic [7:0]       dev_id,
  input  logic [15:0]      prot_status,
  input  logic             eng_rdy,
  output logic             load_req,
  output logic [BLK_W+7:0] load_sec,
  output logic [7:0]       page_addr,
  output logic             warm_rst,
  output logic             load_armed,
  output logic [47:0]      id_words
);
  localparam logic [15:0] LOW_WIN_END  = 16'h01FF;
  localparam logic [15:0] HIGH_WIN_BEG = 16'h8000;
  localparam logic [15:0] HIGH_WIN_END = 16'h800F;
  localparam logic [15:0] OP_ARM   = 16'h00E0;
  localparam logic [15:0] OP_GO    = 16'h0000;
  localparam logic [15:0] OP_RESET = 16'h00F0;
  localparam logic [15:0] OP_IDENT = 16'h0090;

  logic             in_win, hit, confirm, do_arm, do_rst, do_id;
  logic             pend;
  logic [BLK_W-1:0] blk_field;

  assign in_win = (wr_addr <= LOW_WIN_END) ||
                  (wr_addr >= HIGH_WIN_BEG && wr_addr <= HIGH_WIN_END);
  assign hit     = wr_en && in_win;
  assign confirm = hit && load_armed && (wr_data == OP_GO);
  assign do_arm  = hit && !load_armed && (wr_data == OP_ARM);
  assign do_rst  = hit && !load_armed && (wr_data == OP_RESET);
  assign do_id   = hit && !load_armed && (wr_data == OP_IDENT);

  assign blk_field = blk_addr[BLK_W-1:0] | (blk_addr[15] ? DENS_MASK : '0);
  assign load_req  = pend && eng_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_armed <= 1'b0;
      warm_rst   <= 1'b0;
    end else begin
      warm_rst <= do_rst;
      if (do_arm)
        load_armed <= 1'b1;
      else if (hit || do_rst)
        load_armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      load_sec  <= '0;
      page_addr <= '0;
    end else begin
      if (confirm) begin
        pend     <= 1'b1;
        load_sec <= {blk_field, page_addr};
      end else if (load_req) begin
        pend <= 1'b0;
      end
      if (pg_wr)
        page_addr <= pg_wdata;
      else if (confirm)
        page_addr <= page_addr + 8'd4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      id_words <= '0;
    else if (do_id)
      id_words <= {8'h00, prot_status[7:0], 8'h00, dev_id, 8'h00, mfr_id};
  end
endmodule

module boot_cmd_decoder_chk #(
  parameter int BLK_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [15:0]      wr_addr,
  input logic [15:0]      wr_data,
  input logic             pg_wr,
  input logic [7:0]       pg_wdata,
  input logic [7:0]       mfr_id,
  input logic [7:0]       dev_id,
  input logic [15:0]      prot_status,
  input logic             eng_rdy,
  input logic             load_req,
  input logic [BLK_W+7:0] load_sec,
  input logic [7:0]       page_addr,
  input logic             warm_rst,
  input logic             load_armed,
  input logic [47:0]      id_words
);
  logic win_c;
  assign win_c = (wr_addr < 16'h0200) || (wr_addr[15:4] == 12'h800);

  p_out_of_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !win_c && !pg_wr) |=> ($stable(page_addr) && $stable(id_words) && !warm_rst
                                     && $stable(load_armed)));

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win_c && !load_armed && wr_data == 16'h00E0) |=> load_armed);

  p_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win_c && load_armed) |=> (!load_armed && !warm_rst && $stable(id_words)));

  p_ready_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> eng_rdy);

  p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win_c && load_armed && wr_data == 16'h0000 && !pg_wr)
      |=> page_addr == $past(page_addr) + 8'd4);

  p_warm_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win_c && !load_armed && wr_data == 16'h00F0) |=> (warm_rst && !load_armed));

  p_ident_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win_c && !load_armed && wr_data == 16'h0090)
      |=> id_words == {8'h00, $past(prot_status[7:0]), 8'h00, $past(dev_id), 8'h00, $past(mfr_id)});
endmodule

bind boot_cmd_decoder boot_cmd_decoder_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pg_wr(pg_wr), .pg_wdata(pg_wdata), .mfr_id(mfr_id), .dev_id(dev_id),
  .prot_status(prot_status), .eng_rdy(eng_rdy), .load_req(load_req),
  .load_sec(load_sec), .page_addr(page_addr), .warm_rst(warm_rst),
  .load_armed(load_armed), .id_words(id_words)
);

// File: tb/tb_boot_cmd_decoder.sv
module tb_boot_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 12;
  localparam logic [BLK_W-1:0] DMASK = 12'h800;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, pg_wr = 0, eng_rdy = 1;
  logic [15:0] wr_addr = 0, wr_data = 0, blk_addr = 0, prot_status = 0;
  logic [7:0] pg_wdata = 0, mfr_id = 0, dev_id = 0;
  logic load_req, warm_rst, load_armed;
  logic [BLK_W+7:0] load_sec;
  logic [7:0] page_addr;
  logic [47:0] id_words;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_cmd_decoder #(.BLK_W(BLK_W), .DENS_MASK(DMASK)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pg_wr(pg_wr), .pg_wdata(pg_wdata), .blk_addr(blk_addr), .mfr_id(mfr_id),
    .dev_id(dev_id), .prot_status(prot_status), .eng_rdy(eng_rdy),
    .load_req(load_req), .load_sec(load_sec), .page_addr(page_addr),
    .warm_rst(warm_rst), .load_armed(load_armed), .id_words(id_words));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_page(input logic [7:0] p);
    @(negedge clk);
    pg_wr = 1; pg_wdata = p;
    @(negedge clk);
    pg_wr = 0;
  endtask

  function automatic logic [BLK_W+7:0] sec_of(input logic [15:0] b, input logic [7:0] p);
    logic [BLK_W-1:0] f;
    f = b[BLK_W-1:0];
    if (b[15]) f = f | DMASK;
    return {f, p};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] saved;
    logic [15:0] outs [4];
    outs[0] = 16'h0200; outs[1] = 16'h8010; outs[2] = 16'h7FFF; outs[3] = 16'hF220;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", {load_armed, load_req, warm_rst, page_addr}, 0);
    chk("R10", id_words, 0);

    // R8 identification fill
    mfr_id = 8'hEC; dev_id = 8'h5A; prot_status = 16'h1234;
    wr(16'h0000, 16'h0090);
    chk("R8", id_words, {8'h00, 8'h34, 8'h00, 8'h5A, 8'h00, 8'hEC});
    saved = id_words;

    // R1 out-of-window writes ignored
    mfr_id = 8'h11;
    for (int i = 0; i < 4; i++) begin
      wr(outs[i], 16'h0090);
      chk("R1", id_words, saved);
      wr(outs[i], 16'h00F0);
      chk("R1", warm_rst, 0);
      wr(outs[i], 16'h00E0);
      chk("R1", load_armed, 0);
    end

    // R9 other values ignored
    wr(16'h8003, 16'h0055);
    chk("R9", {load_armed, warm_rst, load_req}, 0);
    chk("R9", id_words, saved);

    // R7 warm reset pulse, edges of both windows
    wr(16'h01FF, 16'h00F0);
    chk("R7", warm_rst, 1);
    @(negedge clk);
    chk("R7", warm_rst, 0);
    wr(16'h800F, 16'h00F0);
    chk("R7", {warm_rst, load_armed}, 2'b10);

    // R2 arm, R3 consumed commands
    wr(16'h8000, 16'h00E0);
    chk("R2", load_armed, 1);
    chk("R2", {load_req, warm_rst}, 0);
    wr(16'h0100, 16'h00F0);
    chk("R3", {load_armed, warm_rst, load_req}, 0);
    wr(16'h0100, 16'h0000);
    @(negedge clk);
    chk("R3", {load_req, page_addr}, 0);
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0090);
    chk("R3", {load_armed, id_words}, {1'b0, saved});
    // R1 out-of-window write does not disarm
    wr(16'h0000, 16'h00E0);
    wr(16'h0300, 16'h1111);
    chk("R1", load_armed, 1);
    wr(16'h0000, 16'h1111);
    chk("R3", {load_armed, load_req}, 0);

    // R4 R6 page sweep with density mask
    blk_addr = 16'h8005;
    for (int p = 0; p < 256; p++) begin
      set_page(p[7:0]);
      wr(16'h0040, 16'h00E0);
      wr(16'h0040, 16'h0000);
      chk("R4", {load_req, load_sec}, {1'b1, sec_of(blk_addr, p[7:0])});
      chk("R6", page_addr, (p + 4) % 256);
      @(negedge clk);
      chk("R5", load_req, 0);
    end
    // R4 block sweep without mask bit
    for (int b = 0; b < 4096; b += 273) begin
      blk_addr = b[15:0];
      set_page(8'hFD);
      wr(16'h8001, 16'h00E0);
      wr(16'h8001, 16'h0000);
      chk("R4", load_sec, sec_of(blk_addr, 8'hFD));
      chk("R6", page_addr, 8'h01);
    end

    // R5 hold-off and replacement
    blk_addr = 16'h0123;
    eng_rdy = 0;
    set_page(8'h10);
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0000);
    repeat (3) begin
      chk("R5", load_req, 0);
      @(negedge clk);
    end
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0000);
    chk("R5", load_req, 0);
    eng_rdy = 1;
    #1;
    chk("R5", {load_req, load_sec}, {1'b1, sec_of(16'h0123, 8'h14)});
    @(negedge clk);
    chk("R5", load_req, 0);

    // R6 host page write wins over advance
    set_page(8'h40);
    wr(16'h0000, 16'h00E0);
    @(negedge clk);
    wr_en = 1; wr_addr = 16'h0000; wr_data = 16'h0000; pg_wr = 1; pg_wdata = 8'h99;
    @(negedge clk);
    wr_en = 0; pg_wr = 0;
    chk("R6", page_addr, 8'h99);
    chk("R6", load_sec, sec_of(16'h0123, 8'h40));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule